// File: doc/BRIEF.md
# Scaled-Index Operand Address Evaluator

This block resolves one instruction operand per request for a 64-bit register-memory datapath. Each request carries a decoded operand descriptor. An immediate operand returns its constant. A register operand returns the contents of the named register. A memory operand forms an effective address from three terms: a sign-extended displacement, an optional base register and an optional index register shifted by a scale. The register file is read through two combinational ports, one for the register or base operand and one for the index.

For a memory operand the block has two modes. In address-only mode it returns the effective address itself, in the request cycle, and issues no memory read. This serves load-effective-address style instructions. In value mode it issues one read on a synchronous memory port and returns the read data on the following cycle. During that cycle the block lowers its ready output and takes no new request.

Top module: `opnd_eval`

## Requirements
- R1: An accepted request of kind 2'b00 (immediate) gives `res_valid`=1 and `res_value`=`req_imm` in the same cycle, and `mem_rd_en` stays 0.
- R2: An accepted request of kind 2'b01 (register) drives `rf_addr_a`=`req_reg` and gives `res_valid`=1 with `res_value` equal to that register's contents in the same cycle, with no memory read.
- R3: For kind 2'b10 (memory), the effective address is computed modulo 2^64 as the 32-bit `req_disp` sign-extended to 64 bits, plus the base register when `req_base_en`=1 (otherwise 0), plus the index register times 2^`req_scale` when `req_idx_en`=1 (otherwise 0). `req_scale` 0,1,2,3 selects the factors 1,2,4,8. The base and index registers are read through `rf_addr_a`=`req_base` and `rf_addr_b`=`req_idx`.
- R4: An accepted memory request with `req_lea`=0 raises `mem_rd_en` with `mem_addr` equal to the effective address in the request cycle, gives `res_valid`=0 in that cycle, and gives `res_valid`=1 with `res_value`=`mem_rdata` on the next cycle.
- R5: An accepted memory request with `req_lea`=1 gives `res_valid`=1 and `res_value` equal to the effective address in the same cycle, and `mem_rd_en` stays 0.
- R6: `req_ready` is 0 in the cycle after a memory read is issued and 1 otherwise. A request presented while `req_ready`=0 is ignored: it causes no memory read, and it produces no result in that cycle or later.
- R7: While `rst_n` is low, `res_valid`=0, `mem_rd_en`=0 and `req_ready`=1.
- R8: With `req_valid`=0 and no read outstanding, or with kind 2'b11 (reserved), `res_valid`=0 and `mem_rd_en`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Operand request present |
| req_ready | output | 1 | Block can take a request this cycle |
| req_kind | input | 2 | 00 immediate, 01 register, 10 memory, 11 reserved |
| req_lea | input | 1 | Memory kind only: return the address instead of reading memory |
| req_imm | input | 64 | Immediate constant |
| req_reg | input | 4 | Register number for the register kind |
| req_base_en | input | 1 | Base register term present |
| req_base | input | 4 | Base register number |
| req_idx_en | input | 1 | Index register term present |
| req_idx | input | 4 | Index register number |
| req_scale | input | 2 | log2 of the index scale factor |
| req_disp | input | 32 | Signed displacement |
| rf_addr_a | output | 4 | Register file port A read number (register or base) |
| rf_data_a | input | 64 | Register file port A read data |
| rf_addr_b | output | 4 | Register file port B read number (index) |
| rf_data_b | input | 64 | Register file port B read data |
| mem_rd_en | output | 1 | Memory read strobe |
| mem_addr | output | 64 | Memory read address |
| mem_rdata | input | 64 | Memory read data, one cycle after the strobe |
| res_valid | output | 1 | Result present |
| res_value | output | 64 | Operand value or effective address |

## Verification
The assertions take three things for granted. The register file answers combinationally in the cycle its read number is driven. The memory returns data on exactly the cycle after the read strobe. A request is counted only in a cycle where both valid and ready are high. The stimulus models the register file and memory with exactly that timing. It holds each request for a single cycle and then drops valid, so that a memory result is sampled with no request competing. The only request made while ready is low is a deliberate one, used to show that it is dropped.

// File: rtl/opnd_pkg.sv
package opnd_pkg;
  typedef enum logic [1:0] {
    OK_IMM = 2'b00,
    OK_REG = 2'b01,
    OK_MEM = 2'b10,
    OK_RSV = 2'b11
  } opnd_kind_e;
endpackage

// File: rtl/opnd_agen.sv
module opnd_agen #(
  parameter int XLEN   = 64,
  parameter int DISP_W = 32,
  parameter int SCL_W  = 2
) (
  input  logic [XLEN-1:0]   base_val,
  input  logic              base_en,
  input  logic [XLEN-1:0]   idx_val,
  input  logic              idx_en,
  input  logic [SCL_W-1:0]  scale,
  input  logic [DISP_W-1:0] disp,
  output logic [XLEN-1:0]   ea
);
  localparam int NSCALE = 1 << SCL_W;
  localparam int EXT_W  = XLEN - DISP_W;

  logic [XLEN-1:0] scaled [NSCALE];
  logic [XLEN-1:0] disp_ext;
  logic [XLEN-1:0] base_term;
  logic [XLEN-1:0] idx_term;

  // one shifted copy of the index per scale code
  for (genvar s = 0; s < NSCALE; s++) begin : g_scale
    assign scaled[s] = idx_val << s;
  end

  always_comb begin
    disp_ext  = {{EXT_W{disp[DISP_W-1]}}, disp};
    base_term = base_en ? base_val : '0;
    idx_term  = idx_en ? scaled[scale] : '0;
    ea        = disp_ext + base_term + idx_term;
  end
endmodule

// File: rtl/opnd_ctl.sv
module opnd_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic fire_rd,
  output logic busy
);
  logic busy_d;
  logic busy_en;

  always_comb begin
    busy_d  = fire_rd;
    busy_en = fire_rd | busy;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
    end else if (busy_en) begin
      busy <= busy_d;
    end
  end

  // R4: an issued read is always followed by a result cycle
  a_r4_read_then_busy: assert property (@(posedge clk) disable iff (!rst_n)
    fire_rd |=> busy);

  // R6: the busy window lasts exactly one cycle
  a_r6_busy_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> !busy);
endmodule

// File: rtl/opnd_sel.sv
module opnd_sel
  import opnd_pkg::*;
#(
  parameter int XLEN  = 64,
  parameter int RID_W = 4
) (
  input  opnd_kind_e        kind,
  input  logic              accept,
  input  logic              lea,
  input  logic              busy,
  input  logic [XLEN-1:0]   imm,
  input  logic [RID_W-1:0]  reg_id,
  input  logic [RID_W-1:0]  base_id,
  input  logic [XLEN-1:0]   rf_a,
  input  logic [XLEN-1:0]   ea,
  input  logic [XLEN-1:0]   mem_rdata,
  output logic [RID_W-1:0]  rf_addr_a,
  output logic              res_valid,
  output logic [XLEN-1:0]   res_value
);
  always_comb begin
    rf_addr_a = (kind == OK_REG) ? reg_id : base_id;
  end

  always_comb begin
    res_valid = 1'b0;
    res_value = '0;
    if (busy) begin
      res_valid = 1'b1;
      res_value = mem_rdata;
    end else if (accept) begin
      unique case (kind)
        OK_IMM: begin
          res_valid = 1'b1;
          res_value = imm;
        end
        OK_REG: begin
          res_valid = 1'b1;
          res_value = rf_a;
        end
        OK_MEM: begin
          if (lea) begin
            res_valid = 1'b1;
            res_value = ea;
          end
        end
        default: begin
          res_valid = 1'b0;
          res_value = '0;
        end
      endcase
    end
  end
endmodule

// File: rtl/opnd_eval.sv
module opnd_eval
  import opnd_pkg::*;
#(
  parameter int XLEN   = 64,
  parameter int NREG   = 16,
  parameter int DISP_W = 32,
  parameter int SCL_W  = 2,
  localparam int RID_W = $clog2(NREG)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [1:0]        req_kind,
  input  logic              req_lea,
  input  logic [XLEN-1:0]   req_imm,
  input  logic [RID_W-1:0]  req_reg,
  input  logic              req_base_en,
  input  logic [RID_W-1:0]  req_base,
  input  logic              req_idx_en,
  input  logic [RID_W-1:0]  req_idx,
  input  logic [SCL_W-1:0]  req_scale,
  input  logic [DISP_W-1:0] req_disp,
  output logic [RID_W-1:0]  rf_addr_a,
  input  logic [XLEN-1:0]   rf_data_a,
  output logic [RID_W-1:0]  rf_addr_b,
  input  logic [XLEN-1:0]   rf_data_b,
  output logic              mem_rd_en,
  output logic [XLEN-1:0]   mem_addr,
  input  logic [XLEN-1:0]   mem_rdata,
  output logic              res_valid,
  output logic [XLEN-1:0]   res_value
);
  opnd_kind_e      kind;
  logic            accept;
  logic            busy;
  logic [XLEN-1:0] ea;

  always_comb begin
    kind      = opnd_kind_e'(req_kind);
    req_ready = ~busy;
    accept    = req_valid & req_ready;
    mem_rd_en = accept & (kind == OK_MEM) & ~req_lea;
    mem_addr  = ea;
    rf_addr_b = req_idx;
  end

  opnd_agen #(.XLEN(XLEN), .DISP_W(DISP_W), .SCL_W(SCL_W)) i_agen (
    .base_val (rf_data_a),
    .base_en  (req_base_en),
    .idx_val  (rf_data_b),
    .idx_en   (req_idx_en),
    .scale    (req_scale),
    .disp     (req_disp),
    .ea       (ea)
  );

  opnd_ctl i_ctl (
    .clk     (clk),
    .rst_n   (rst_n),
    .fire_rd (mem_rd_en),
    .busy    (busy)
  );

  opnd_sel #(.XLEN(XLEN), .RID_W(RID_W)) i_sel (
    .kind      (kind),
    .accept    (accept),
    .lea       (req_lea),
    .busy      (busy),
    .imm       (req_imm),
    .reg_id    (req_reg),
    .base_id   (req_base),
    .rf_a      (rf_data_a),
    .ea        (ea),
    .mem_rdata (mem_rdata),
    .rf_addr_a (rf_addr_a),
    .res_valid (res_valid),
    .res_value (res_value)
  );

  // R1: an immediate never touches memory and answers at once
  a_r1_imm_now: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_kind == 2'b00) |->
      (!mem_rd_en && res_valid && res_value == req_imm));

  // R5: address-only mode reports without a read
  a_r5_lea_no_read: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_kind == 2'b10 && req_lea) |->
      (!mem_rd_en && res_valid));

  // R6: no read can start while the previous one is being returned
  a_r6_busy_blocks_read: assert property (@(posedge clk) disable iff (!rst_n)
    !req_ready |-> !mem_rd_en);

  // R4: the read data is forwarded on the cycle after the strobe
  a_r4_data_next: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_en |=> (res_valid && !req_ready));
endmodule

// File: tb/test_opnd_eval.sv
`timescale 1ns/1ps
module test_opnd_eval;
  logic        clk;
  logic        rst_n;
  logic        req_valid;
  logic        req_ready;
  logic [1:0]  req_kind;
  logic        req_lea;
  logic [63:0] req_imm;
  logic [3:0]  req_reg;
  logic        req_base_en;
  logic [3:0]  req_base;
  logic        req_idx_en;
  logic [3:0]  req_idx;
  logic [1:0]  req_scale;
  logic [31:0] req_disp;
  logic [3:0]  rf_addr_a;
  logic [63:0] rf_data_a;
  logic [3:0]  rf_addr_b;
  logic [63:0] rf_data_b;
  logic        mem_rd_en;
  logic [63:0] mem_addr;
  logic [63:0] mem_rdata;
  logic        res_valid;
  logic [63:0] res_value;

  int total;
  int bad;
  logic [63:0] rf [16];

  opnd_eval i_opnd_eval (.*);

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  function automatic logic [63:0] memf(input logic [63:0] a);
    return {a[31:0] ^ 32'h5A5A_C3C3, ~a[63:32]};
  endfunction

  function automatic logic [31:0] disp_of(input int i);
    case (i)
      0: return 32'h0000_0000;
      1: return 32'h0000_0004;
      2: return 32'hFFFF_FFFC;
      3: return 32'hFFFF_FFF8;
      4: return 32'h0000_0800;
      5: return 32'h7FFF_FFFF;
      default: return 32'h8000_0000;
    endcase
  endfunction

  assign rf_data_a = rf[rf_addr_a];
  assign rf_data_b = rf[rf_addr_b];

  always @(posedge clk) if (mem_rd_en) mem_rdata <= memf(mem_addr);

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic idle();
    req_valid = 1'b0; req_kind = 2'b00; req_lea = 1'b0; req_imm = '0;
    req_reg = '0; req_base_en = 1'b0; req_base = '0; req_idx_en = 1'b0;
    req_idx = '0; req_scale = '0; req_disp = '0;
  endtask

  task automatic mem_req(input logic be, input logic [3:0] b, input logic ie,
                         input logic [3:0] x, input logic [1:0] sc,
                         input logic [31:0] d, input logic lea);
    logic [63:0] ea;
    ea = {{32{d[31]}}, d} + (be ? rf[b] : 64'd0) + (ie ? rf[x] * (64'd1 << sc) : 64'd0);
    @(negedge clk);
    req_valid = 1'b1; req_kind = 2'b10; req_lea = lea; req_base_en = be;
    req_base = b; req_idx_en = ie; req_idx = x; req_scale = sc; req_disp = d;
    #1;
    if (lea) begin
      check("R5 lea valid", {63'd0, res_valid}, 64'd1);
      check("R5 lea value R3", res_value, ea);
      check("R5 lea no read", {63'd0, mem_rd_en}, 64'd0);
    end else begin
      check("R4 read strobe", {63'd0, mem_rd_en}, 64'd1);
      check("R3 read address", mem_addr, ea);
      check("R4 no same-cycle result", {63'd0, res_valid}, 64'd0);
      check("R3 base port", {60'd0, rf_addr_a}, {60'd0, b});
      check("R3 index port", {60'd0, rf_addr_b}, {60'd0, x});
    end
    @(negedge clk);
    idle();
    #1;
    if (!lea) begin
      check("R4 result valid", {63'd0, res_valid}, 64'd1);
      check("R4 result data", res_value, memf(ea));
      check("R6 ready low", {63'd0, req_ready}, 64'd0);
    end else begin
      check("R8 idle after lea", {63'd0, res_valid}, 64'd0);
    end
  endtask

  initial begin
    #(200000 * 5);
    bad++;
    total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    total = 0; bad = 0;
    rf[0] = 64'h804; rf[1] = 64'h10; rf[2] = 64'h4; rf[3] = 64'h1;
    rf[4] = 64'hFFFF_FFFF_FFFF_FFF0; rf[5] = 64'h8000_0000_0000_0001;
    for (int i = 6; i < 16; i++) rf[i] = 64'h0123_4567_89AB_CDEF * i;
    idle();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    #1;
    check("R7 reset res_valid", {63'd0, res_valid}, 64'd0);
    check("R7 reset mem_rd_en", {63'd0, mem_rd_en}, 64'd0);
    check("R7 reset ready", {63'd0, req_ready}, 64'd1);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    check("R8 idle res_valid", {63'd0, res_valid}, 64'd0);
    check("R8 idle mem_rd_en", {63'd0, mem_rd_en}, 64'd0);

    // R1 immediates
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      req_valid = 1'b1; req_kind = 2'b00; req_imm = 64'hFEDC_BA98_7654_3210 ^ (64'd1 << (i * 9));
      #1;
      check("R1 imm valid", {63'd0, res_valid}, 64'd1);
      check("R1 imm value", res_value, 64'hFEDC_BA98_7654_3210 ^ (64'd1 << (i * 9)));
      check("R1 imm no read", {63'd0, mem_rd_en}, 64'd0);
    end

    // R2 every register
    for (int r = 0; r < 16; r++) begin
      @(negedge clk);
      req_valid = 1'b1; req_kind = 2'b01; req_reg = 4'(r);
      req_base = 4'(15 - r);
      #1;
      check("R2 reg port", {60'd0, rf_addr_a}, 64'(r));
      check("R2 reg valid", {63'd0, res_valid}, 64'd1);
      check("R2 reg value", res_value, rf[r]);
      check("R2 reg no read", {63'd0, mem_rd_en}, 64'd0);
    end

    // R8 reserved kind
    @(negedge clk);
    req_valid = 1'b1; req_kind = 2'b11; req_lea = 1'b0; #1;
    check("R8 reserved res_valid", {63'd0, res_valid}, 64'd0);
    check("R8 reserved mem_rd_en", {63'd0, mem_rd_en}, 64'd0);
    @(negedge clk); idle();

    // R3 R4 R5 sweep over address forms
    for (int be = 0; be < 2; be++)
      for (int ie = 0; ie < 2; ie++)
        for (int sc = 0; sc < 4; sc++)
          for (int di = 0; di < 7; di++)
            for (int bi = 0; bi < 3; bi++)
              for (int xi = 0; xi < 3; xi++)
                for (int ls = 0; ls < 2; ls++)
                  mem_req(1'(be), 4'(bi == 0 ? 0 : bi + 3), 1'(ie),
                          4'(xi == 0 ? 3 : xi + 1), 2'(sc), disp_of(di), 1'(ls));

    // R6 request during busy cycle is dropped
    @(negedge clk);
    req_valid = 1'b1; req_kind = 2'b10; req_lea = 1'b0; req_base_en = 1'b1;
    req_base = 4'd0; req_disp = 32'h8;
    @(negedge clk);
    req_kind = 2'b00; req_imm = 64'h1111_2222_3333_4444; req_lea = 1'b0;
    #1;
    check("R6 busy ready low", {63'd0, req_ready}, 64'd0);
    check("R6 busy no read", {63'd0, mem_rd_en}, 64'd0);
    check("R6 busy gives memory data", res_value, memf(64'h80C));
    @(negedge clk);
    idle(); #1;
    check("R6 dropped request no result", {63'd0, res_valid}, 64'd0);
    check("R6 ready back", {63'd0, req_ready}, 64'd1);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule